// File: doc/BRIEF.md
# Calibration Sample Detector and Router

This block sits behind the serial capture stage of one converter channel. It watches the control line that switches that channel's input multiplexer onto the calibration signal. It then decides, word by word, whether each captured sample is a calibration sample or a normal sample. The sub-converter has a conversion latency. For that reason the word captured while the multiplexer passes the calibration signal still belongs to the previous input, and the sample that follows it is the one taken from the calibration signal.

The control line is asynchronous. It is brought into the system clock through a flop synchroniser, and a falling edge seen after the synchroniser arms the block. The next word whose valid flag rises is tagged as calibration data and goes to the correction port. Every other word goes to the output-multiplexer port. Once the tagged word's valid flag drops, the block returns to idle and waits for the next falling edge. Both output streams are registered and carry a one-cycle strobe per word.

Top module: `cal_route_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, both strobes are 0 and both data outputs are 0. A reset clears any pending arming, so the first word after reset goes to the output-multiplexer port.
- R2: Only a high-to-low transition of `mux_ctrl`, after the two-flop synchroniser, arms the block. A low-to-high transition does not arm it.
- R3: When the block is armed, the next word whose `din_valid` rises is presented on `corr_valid`/`corr_word`.
- R4: When the block is not armed, every word goes to `omux_valid`/`omux_word`. This includes a word captured while `mux_ctrl` is still high.
- R5: After a tagged word's `din_valid` goes low, the block is idle again. Later words go to the output-multiplexer port until a new falling edge arrives.
- R6: A second falling edge that arrives while the block is already armed has no extra effect. Exactly one following word is tagged.
- R7: A falling edge that arrives while the tagged calibration word is still valid is ignored. The word after it goes to the output-multiplexer port.
- R8: Each rising edge of `din_valid` produces exactly one strobe, one clock long, in the cycle after the edge is sampled. The two strobes are never high together.
- R9: Each data output keeps its last value between its strobes and changes only together with its own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_ctrl | input | 1 | Asynchronous input-multiplexer control line; high while the calibration signal is selected |
| din | input | 16 | Parallel word from the serial capture stage |
| din_valid | input | 1 | High while `din` holds a newly captured word |
| corr_valid | output | 1 | One-cycle strobe for a calibration word |
| corr_word | output | 16 | Calibration word for the correction logic |
| omux_valid | output | 1 | One-cycle strobe for a normal word |
| omux_word | output | 16 | Normal word for the output multiplexer |

## Verification
The bench sends plain words with no control activity, which shows that idle routing always goes to the output-multiplexer port. It then runs single control pulses with a word captured while the line is still high and another captured after the line falls. This separates the latency-shifted tag from a tag on the wrong word. Repeated falling edges before a word, a falling edge in the middle of a tagged word, a rising edge on its own and a reset while armed each show whether arming is counted once, ignored, or cleared. Long-held valid flags show that a word gives only one strobe, however long its valid flag stays high.

// File: rtl/cal_route_pkg.sv
package cal_route_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_TAGGED = 2'd2
  } arm_state_e;

endpackage

// File: rtl/cal_ctrl_sync.sv
module cal_ctrl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_async,
  output logic fall_pulse
);

  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  // chain[0] takes the raw input; chain[STAGES-1] is the synchronised level
  // and chain[STAGES] holds its value from one cycle earlier.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain <= {chain[CHAIN_W-2:0], ctrl_async};
    end
  end

  assign fall_pulse = chain[STAGES] & ~chain[STAGES-1];

endmodule

// File: rtl/cal_arm_fsm.sv
module cal_arm_fsm
  import cal_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fall_pulse,
  input  logic       word_start,
  input  logic       din_valid,
  output arm_state_e state,
  output logic       tag_now
);

  arm_state_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (fall_pulse) state_nx = ST_ARMED;
      ST_ARMED:  if (word_start) state_nx = ST_TAGGED;
      ST_TAGGED: if (!din_valid) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= state_nx;
    end
  end

  assign tag_now = (state == ST_ARMED) && word_start;

endmodule

// File: rtl/cal_word_router.sv
module cal_word_router #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              din_valid,
  input  logic              tag_now,
  output logic              word_start,
  output logic              corr_valid,
  output logic [DATA_W-1:0] corr_word,
  output logic              omux_valid,
  output logic [DATA_W-1:0] omux_word
);

  logic valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= din_valid;
    end
  end

  assign word_start = din_valid & ~valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_valid <= 1'b0;
      omux_valid <= 1'b0;
      corr_word  <= '0;
      omux_word  <= '0;
    end else begin
      corr_valid <= word_start & tag_now;
      omux_valid <= word_start & ~tag_now;
      if (word_start && tag_now) begin
        corr_word <= din;
      end
      if (word_start && !tag_now) begin
        omux_word <= din;
      end
    end
  end

endmodule

// File: rtl/cal_route_top.sv
module cal_route_top
  import cal_route_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mux_ctrl,
  input  logic [DATA_W-1:0] din,
  input  logic              din_valid,
  output logic              corr_valid,
  output logic [DATA_W-1:0] corr_word,
  output logic              omux_valid,
  output logic [DATA_W-1:0] omux_word
);

  logic       ctrl_fall;
  logic       word_start;
  logic       tag_now;
  arm_state_e arm_state;

  cal_ctrl_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .ctrl_async(mux_ctrl),
    .fall_pulse(ctrl_fall)
  );

  cal_arm_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .fall_pulse(ctrl_fall),
    .word_start(word_start),
    .din_valid (din_valid),
    .state     (arm_state),
    .tag_now   (tag_now)
  );

  cal_word_router #(
    .DATA_W(DATA_W)
  ) u_router (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .din_valid (din_valid),
    .tag_now   (tag_now),
    .word_start(word_start),
    .corr_valid(corr_valid),
    .corr_word (corr_word),
    .omux_valid(omux_valid),
    .omux_word (omux_word)
  );

endmodule

// File: rtl/cal_route_checker.sv
module cal_route_checker
  import cal_route_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              din_valid,
  input logic              fall_pulse,
  input arm_state_e        state,
  input logic              corr_valid,
  input logic [DATA_W-1:0] corr_word,
  input logic              omux_valid,
  input logic [DATA_W-1:0] omux_word
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!corr_valid && !omux_valid && corr_word == '0 && omux_word == '0));

  assert_fall_arms_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && fall_pulse) |=> (state == ST_ARMED));

  assert_cal_needs_arm_R3: assert property (@(posedge clk) disable iff (rst)
    corr_valid |-> ($past(state) == ST_ARMED));

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAGGED && !din_valid) |=> (state == ST_IDLE));

  assert_one_port_R8: assert property (@(posedge clk) disable iff (rst)
    !(corr_valid && omux_valid));

  assert_strobe_after_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (corr_valid || omux_valid) |-> $past(din_valid));

  assert_short_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    (corr_valid || omux_valid) |=> !(corr_valid || omux_valid));

  assert_corr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !corr_valid |-> $stable(corr_word));

  assert_omux_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !omux_valid |-> $stable(omux_word));

endmodule

bind cal_route_top cal_route_checker #(
  .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .din_valid (din_valid),
  .fall_pulse(ctrl_fall),
  .state     (arm_state),
  .corr_valid(corr_valid),
  .corr_word (corr_word),
  .omux_valid(omux_valid),
  .omux_word (omux_word)
);

// File: tb/cal_route_top_bench.sv
`timescale 1ns/1ps
module cal_route_top_bench;

  localparam int DW = 16;

  typedef struct {
    bit          cal;
    logic [DW-1:0] data;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mux_ctrl = 1'b0;
  logic [DW-1:0] din = '0;
  logic          din_valid = 1'b0;
  logic          corr_valid, omux_valid;
  logic [DW-1:0] corr_word, omux_word;

  int   total = 0;
  int   bad = 0;
  int   pushed = 0;
  int   seen = 0;
  bit   done = 1'b0;
  bit   model_armed = 1'b0;
  bit   prev_strobe = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  cal_route_top u_cal_route_top (
    .clk(clk), .rst(rst), .mux_ctrl(mux_ctrl), .din(din), .din_valid(din_valid),
    .corr_valid(corr_valid), .corr_word(corr_word),
    .omux_valid(omux_valid), .omux_word(omux_word)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit strobe;
      strobe = corr_valid | omux_valid;
      if (corr_valid && omux_valid)
        check(1'b0, "R8", "both strobes high", 32'd2, 32'd1);
      if (strobe && prev_strobe)
        check(1'b0, "R8", "strobe longer than one cycle", 32'd2, 32'd1);
      if (strobe) begin
        seen++;
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected strobe", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(corr_valid == e.cal, e.tag, "port choice (1=correction)",
                {31'd0, corr_valid}, {31'd0, e.cal});
          check((e.cal ? corr_word : omux_word) == e.data, e.tag, "word value",
                {16'd0, (e.cal ? corr_word : omux_word)}, {16'd0, e.data});
          check((e.cal ? omux_word : corr_word) == (e.cal ? $past(omux_word) : $past(corr_word)),
                "R9", "other port word changed", 32'd1, 32'd0);
        end
      end
      prev_strobe = strobe;
    end
  end

  // Driver: one word, valid held for `hold` cycles
  task automatic send_word(input logic [DW-1:0] d, input int hold, input string tag);
    exp_t e;
    e.cal  = model_armed;
    e.data = d;
    e.tag  = tag;
    q.push_back(e);
    pushed++;
    model_armed = 1'b0;
    din = d;
    din_valid = 1'b1;
    @(negedge clk);
    check(corr_valid | omux_valid, "R8", "strobe one cycle after valid rise",
          {31'd0, corr_valid | omux_valid}, 32'd1);
    idle(hold - 1);
    din_valid = 1'b0;
    idle(3);
  endtask

  // Driver: word with a full control pulse inside its valid window (R7)
  task automatic send_word_pulse_inside(input logic [DW-1:0] d, input string tag);
    exp_t e;
    e.cal  = model_armed;
    e.data = d;
    e.tag  = tag;
    q.push_back(e);
    pushed++;
    model_armed = 1'b0;
    din = d;
    din_valid = 1'b1;
    idle(2);
    mux_ctrl = 1'b1;
    idle(4);
    mux_ctrl = 1'b0;
    idle(6);
    din_valid = 1'b0;
    idle(3);
  endtask

  task automatic ctrl_pulse();
    mux_ctrl = 1'b1;
    idle(4);
    mux_ctrl = 1'b0;
    idle(5);
    model_armed = 1'b1;
  endtask

  initial begin
    idle(3);
    check(!corr_valid && !omux_valid, "R1", "strobes during reset",
          {30'd0, corr_valid, omux_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!corr_valid && !omux_valid && corr_word == '0 && omux_word == '0, "R1",
          "outputs after reset", {16'd0, corr_word | omux_word}, 32'd0);

    // R4: no control activity, all words normal
    send_word(16'h1111, 1, "R4");
    send_word(16'h2222, 5, "R4");

    // R2/R3/R4/R5: word while ctrl high normal, next after fall is calibration
    mux_ctrl = 1'b1;
    idle(5);
    send_word(16'h3333, 2, "R4");
    mux_ctrl = 1'b0;
    idle(5);
    model_armed = 1'b1;
    send_word(16'hCA11, 20, "R3");
    send_word(16'h4444, 2, "R5");

    // R2: a rising edge alone does not arm
    mux_ctrl = 1'b1;
    idle(6);
    send_word(16'h5555, 2, "R2");
    mux_ctrl = 1'b0;
    idle(5);
    model_armed = 1'b1;
    send_word(16'hCA22, 2, "R3");

    // R6: two falls while armed tag only one word
    ctrl_pulse();
    ctrl_pulse();
    send_word(16'hCA33, 3, "R6");
    send_word(16'h6666, 3, "R6");

    // R7: fall during the tagged word is ignored
    ctrl_pulse();
    send_word_pulse_inside(16'hCA44, "R3");
    send_word(16'h7777, 2, "R7");

    // R1: reset while armed clears arming
    ctrl_pulse();
    rst = 1'b1;
    idle(3);
    check(!corr_valid && !omux_valid && corr_word == '0 && omux_word == '0, "R1",
          "outputs in reset", {16'd0, corr_word | omux_word}, 32'd0);
    rst = 1'b0;
    model_armed = 1'b0;
    prev_strobe = 1'b0;
    idle(2);
    send_word(16'h8888, 2, "R1");

    // back-to-back calibration cycles
    ctrl_pulse();
    send_word(16'hCA55, 1, "R3");
    ctrl_pulse();
    send_word(16'hCA66, 1, "R5");
    send_word(16'h9999, 1, "R5");

    idle(5);
    check(q.size() == 0, "R8", "expected words left over", q.size(), 32'd0);
    check(seen == pushed, "R8", "strobe count", seen, pushed);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule